// File: doc/BRIEF.md
# Strobed Parallel Port Handshake Controller

This block manages one 8-bit bidirectional port and an 8-bit output-only companion port. It uses two strobe lines for that work: an edge-sensitive input strobe `stra_in` and an output strobe `strb_out`. Software reaches five registers through a simple single-cycle register bus. The registers are a control word, a direction word, a port data word, a latched-data word and the companion output word. Pads are presented as output value and output-enable vectors.

The control word selects one of three modes. In simple strobed mode, every write to the companion port fires a strobe pulse, and each active input edge captures the port pins. In full input handshake mode, the output strobe is a "ready" line. In full output handshake mode, it is a "data ready" line, and lines set as inputs become a three-state bus that is driven while the input strobe is held at its active level.

A status flag marks each active input edge. The flag clears through a two-step sequence: a control read, then a latched-data access. An interrupt request is raised when the flag is set and enabled.

The output strobe is run by a three-state machine:
- `ST_IDLE` (strobe negated).
- `ST_PULSE` (asserted for `PULSE_TICKS` E-clock enable ticks).
- `ST_READY` (asserted as a level).

Its transitions are:
- **start**: `ST_IDLE` to `ST_PULSE` or `ST_READY`. This happens on a companion write in simple mode, on a latched-data write in output handshake, or on a latched-data read in input handshake.
- **load**: any state to `ST_PULSE`/`ST_READY`/`ST_IDLE` on a control write. Entering input handshake starts the strobe; every other mode goes idle.
- **expire**: `ST_PULSE` to `ST_IDLE` on the last tick.
- **retrigger**: `ST_PULSE` to `ST_PULSE` on a new companion write in simple mode.
- **ack**: `ST_PULSE`/`ST_READY` to `ST_IDLE` on an active input edge in either handshake mode.

Top module: `strobe_port_ctrl`

## Requirements
- R1: Reset values:
  - The control word reads 0x03 (active-high strobe, rising edge selected).
  - Direction, port data, latched data and companion all read 0.
  - The flag is clear, `strb_out` is 0, `irq` is 0 and `port_oe` is 0.
- R2: The strobe polarity is set by control bit 0 (1 = active high, 0 = active low).
  - In simple mode (control bit 4 = 0), a write to address 4 updates `comp_out`.
  - That write also holds the strobe active for exactly `PULSE_TICKS` (2) `e_tick` ticks.
- R3: Control bit 1 selects the active input-strobe edge (1 = rising, 0 = falling); `stra_in` passes through a two-flop synchronizer first.
  - On the active edge, `port_in` is captured into the latched-data register (address 2) and the flag (control bit 7) is set.
  - The opposite edge changes neither the latched-data register nor the flag.
- R4: Full input handshake is selected by control bit 4 = 1 with bit 3 = 0.
  - The strobe asserts when the mode is entered.
  - It negates on the active input edge.
  - It asserts again after a read of address 2.
- R5: Full output handshake is selected by control bits 4 = 1 and 3 = 1.
  - A write to address 2 stores the data and asserts the strobe.
  - The active input edge negates the strobe and sets the flag.
- R6: With control bit 2 = 1, each handshake strobe assertion is a pulse of `PULSE_TICKS` ticks instead of a level.
- R7: The flag clearing sequence:
  - A control read (address 0) that returns the flag set arms the clearing sequence.
  - The following latched-data read clears the flag; in output handshake mode, a latched-data write does this instead.
  - A latched-data access that is not armed leaves the flag set.
- R8: The direction register (address 3) drives `port_oe` (1 = output).
  - Outside output handshake mode, `port_out` is the port data register (address 1).
  - Reading address 1 returns data bits on output lines and `port_in` bits on input lines.
- R9: In output handshake mode, `port_out` is the latched-data register.
  - Every line is enabled while the synchronized input strobe sits at its active level.
  - Otherwise the direction register decides.
- R10: `irq` is 1 exactly when the flag and control bit 5 are both 1.
- R11: Writes to address 2 outside output handshake mode are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| e_tick | input | 1 | E-clock enable tick for strobe pulse timing |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (read side effects) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| port_in | input | 8 | Bidirectional port pad inputs |
| port_out | output | 8 | Bidirectional port pad output values |
| port_oe | output | 8 | Bidirectional port pad output enables |
| comp_out | output | 8 | Companion output-only port |
| stra_in | input | 1 | Input strobe line (asynchronous) |
| strb_out | output | 1 | Output strobe line |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check the following:
- The flag only rises after a synchronized active edge.
- The flag only falls after a latched-data access.
- Output-direction lines are always enabled.
- The interrupt never appears without the flag.
- The latched data holds still outside output handshake except on an edge.
- A handshake strobe drops after an acknowledge.
- A simple-mode pulse never outlasts its tick budget.

Some behaviours only the bench scenarios can show, against a cycle-by-cycle reference model:
- The exact pulse width under both polarities.
- The ready/acknowledge ordering in each handshake.
- The arming order of the clearing sequence.
- The three-state bus appearing and vanishing with the input strobe level.

// File: rtl/spp_pkg.sv
package spp_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_DATA  = 3'd1;
    localparam logic [ADDR_W-1:0] A_LATCH = 3'd2;
    localparam logic [ADDR_W-1:0] A_DIR   = 3'd3;
    localparam logic [ADDR_W-1:0] A_COMP  = 3'd4;

    localparam int CB_POL   = 0;
    localparam int CB_EDGE  = 1;
    localparam int CB_PULSE = 2;
    localparam int CB_ODIR  = 3;
    localparam int CB_HS    = 4;
    localparam int CB_IE    = 5;
    localparam int CB_FLAG  = 7;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULSE = 2'd1,
        ST_READY = 2'd2
    } strb_state_e;

    typedef enum logic [1:0] {
        MODE_SIMPLE = 2'd0,
        MODE_IN_HS  = 2'd1,
        MODE_OUT_HS = 2'd2
    } port_mode_e;

    function automatic port_mode_e decode_mode(input logic hs, input logic odir);
        if (!hs)  return MODE_SIMPLE;
        if (odir) return MODE_OUT_HS;
        return MODE_IN_HS;
    endfunction
endpackage

// File: rtl/spp_stra_sync.sv
module spp_stra_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stra_in,
    input  logic edge_rise,
    output logic stra_edge,
    output logic stra_at_active
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], stra_in};
            prev_q  <= chain_q[TOP];
        end
    end

    always_comb begin
        stra_edge      = edge_rise ? (chain_q[TOP] & ~prev_q) : (~chain_q[TOP] & prev_q);
        stra_at_active = (chain_q[TOP] == edge_rise);
    end
endmodule

// File: rtl/spp_strb_fsm.sv
module spp_strb_fsm
    import spp_pkg::*;
#(
    parameter int PULSE_TICKS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       e_tick,
    input  port_mode_e mode,
    input  logic       pulse_mode,
    input  logic       mode_load,
    input  port_mode_e load_mode,
    input  logic       load_pulse,
    input  logic       comp_wr,
    input  logic       latch_rd,
    input  logic       latch_wr,
    input  logic       stra_edge,
    output logic       strb_act
);
    localparam int CNT_W = $clog2(PULSE_TICKS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSE_TICKS - 1);

    strb_state_e      st_q, st_d;
    logic [CNT_W-1:0] cnt_q;
    logic             start;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q <= st_d;
            if (start)
                cnt_q <= '0;
            else if (st_q == ST_PULSE && e_tick)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        st_d  = st_q;
        start = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if ((mode == MODE_SIMPLE && comp_wr) ||
                    (mode == MODE_OUT_HS && latch_wr) ||
                    (mode == MODE_IN_HS && latch_rd))
                    start = 1'b1;
            end
            ST_PULSE: begin
                if (mode != MODE_SIMPLE && stra_edge)
                    st_d = ST_IDLE;
                else if (mode == MODE_SIMPLE && comp_wr)
                    start = 1'b1;
                else if (e_tick && cnt_q == LAST)
                    st_d = ST_IDLE;
            end
            ST_READY: begin
                if (mode != MODE_SIMPLE && stra_edge)
                    st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
        if (start)
            st_d = (mode == MODE_SIMPLE || pulse_mode) ? ST_PULSE : ST_READY;
        if (mode_load) begin
            start = (load_mode == MODE_IN_HS);
            if (load_mode == MODE_IN_HS)
                st_d = load_pulse ? ST_PULSE : ST_READY;
            else
                st_d = ST_IDLE;
        end
    end

    always_comb begin
        strb_act = (st_q != ST_IDLE);
    end
endmodule

// File: rtl/spp_pad_mux.sv
module spp_pad_mux #(
    parameter int DATA_W = 8
) (
    input  logic              out_hs,
    input  logic              stra_at_active,
    input  logic [DATA_W-1:0] dir,
    input  logic [DATA_W-1:0] data,
    input  logic [DATA_W-1:0] latch,
    output logic [DATA_W-1:0] port_out,
    output logic [DATA_W-1:0] port_oe
);
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        assign port_oe[b]  = dir[b] | (out_hs & stra_at_active);
        assign port_out[b] = out_hs ? latch[b] : data[b];
    end
endmodule

// File: rtl/strobe_port_ctrl.sv
module strobe_port_ctrl
    import spp_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int PULSE_TICKS = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              e_tick,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] port_in,
    output logic [DATA_W-1:0] port_out,
    output logic [DATA_W-1:0] port_oe,
    output logic [DATA_W-1:0] comp_out,
    input  logic              stra_in,
    output logic              strb_out,
    output logic              irq
);
    logic pol_q, edge_q, pulse_q, odir_q, hs_q, ie_q;
    logic flag_q, arm_q;
    logic [DATA_W-1:0] dir_q, data_q, latch_q, comp_q;

    logic wr, rd, ctrl_wr, ctrl_rd, data_wr, dir_wr, comp_wr, latch_wr, latch_rd;
    logic stra_edge, stra_at_active, strb_act, flag_clr;
    logic in_out_hs;
    port_mode_e mode, load_mode;

    assign wr       = bus_sel & bus_wr;
    assign rd       = bus_sel & bus_rd;
    assign ctrl_wr  = wr && bus_addr == A_CTRL;
    assign ctrl_rd  = rd && bus_addr == A_CTRL;
    assign data_wr  = wr && bus_addr == A_DATA;
    assign dir_wr   = wr && bus_addr == A_DIR;
    assign comp_wr  = wr && bus_addr == A_COMP;
    assign latch_wr = wr && bus_addr == A_LATCH;
    assign latch_rd = rd && bus_addr == A_LATCH;

    assign mode      = decode_mode(hs_q, odir_q);
    assign load_mode = decode_mode(bus_wdata[CB_HS], bus_wdata[CB_ODIR]);
    assign in_out_hs = (mode == MODE_OUT_HS);
    assign flag_clr  = arm_q && (in_out_hs ? latch_wr : latch_rd);

    spp_stra_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk            (clk),
        .rst_n          (rst_n),
        .stra_in        (stra_in),
        .edge_rise      (edge_q),
        .stra_edge      (stra_edge),
        .stra_at_active (stra_at_active)
    );

    spp_strb_fsm #(.PULSE_TICKS(PULSE_TICKS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .e_tick     (e_tick),
        .mode       (mode),
        .pulse_mode (pulse_q),
        .mode_load  (ctrl_wr),
        .load_mode  (load_mode),
        .load_pulse (bus_wdata[CB_PULSE]),
        .comp_wr    (comp_wr),
        .latch_rd   (latch_rd),
        .latch_wr   (latch_wr),
        .stra_edge  (stra_edge),
        .strb_act   (strb_act)
    );

    spp_pad_mux #(.DATA_W(DATA_W)) u_pads (
        .out_hs         (in_out_hs),
        .stra_at_active (stra_at_active),
        .dir            (dir_q),
        .data           (data_q),
        .latch          (latch_q),
        .port_out       (port_out),
        .port_oe        (port_oe)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pol_q   <= 1'b1;
            edge_q  <= 1'b1;
            pulse_q <= 1'b0;
            odir_q  <= 1'b0;
            hs_q    <= 1'b0;
            ie_q    <= 1'b0;
            dir_q   <= '0;
            data_q  <= '0;
            comp_q  <= '0;
        end else begin
            if (ctrl_wr) begin
                pol_q   <= bus_wdata[CB_POL];
                edge_q  <= bus_wdata[CB_EDGE];
                pulse_q <= bus_wdata[CB_PULSE];
                odir_q  <= bus_wdata[CB_ODIR];
                hs_q    <= bus_wdata[CB_HS];
                ie_q    <= bus_wdata[CB_IE];
            end
            if (dir_wr)  dir_q  <= bus_wdata;
            if (data_wr) data_q <= bus_wdata;
            if (comp_wr) comp_q <= bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q  <= 1'b0;
            arm_q   <= 1'b0;
            latch_q <= '0;
        end else begin
            if (stra_edge)      flag_q <= 1'b1;
            else if (flag_clr)  flag_q <= 1'b0;
            if (ctrl_rd && flag_q) arm_q <= 1'b1;
            else if (flag_clr)     arm_q <= 1'b0;
            if (stra_edge && !in_out_hs)     latch_q <= port_in;
            else if (latch_wr && in_out_hs)  latch_q <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CTRL: begin
                bus_rdata[CB_POL]   = pol_q;
                bus_rdata[CB_EDGE]  = edge_q;
                bus_rdata[CB_PULSE] = pulse_q;
                bus_rdata[CB_ODIR]  = odir_q;
                bus_rdata[CB_HS]    = hs_q;
                bus_rdata[CB_IE]    = ie_q;
                bus_rdata[CB_FLAG]  = flag_q;
            end
            A_DATA:  bus_rdata = (data_q & dir_q) | (port_in & ~dir_q);
            A_LATCH: bus_rdata = latch_q;
            A_DIR:   bus_rdata = dir_q;
            A_COMP:  bus_rdata = comp_q;
            default: bus_rdata = '0;
        endcase
    end

    assign comp_out = comp_q;
    assign strb_out = pol_q ? strb_act : ~strb_act;
    assign irq      = flag_q & ie_q;
endmodule

// File: rtl/spp_port_chk.sv
module spp_port_chk
    import spp_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int PULSE_TICKS = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              e_tick,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] port_oe,
    input logic [DATA_W-1:0] dir_q,
    input logic [DATA_W-1:0] latch_q,
    input logic              irq,
    input logic              flag_q,
    input logic              stra_edge,
    input logic              strb_act,
    input logic              hs_q,
    input logic              in_out_hs
);
    logic [7:0] tick_cnt;
    logic       ctrl_w, comp_w;

    assign ctrl_w = bus_sel && bus_wr && bus_addr == A_CTRL;
    assign comp_w = bus_sel && bus_wr && bus_addr == A_COMP;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tick_cnt <= '0;
        else if (!strb_act || hs_q || comp_w || ctrl_w)
            tick_cnt <= '0;
        else if (e_tick && tick_cnt != 8'hFF)
            tick_cnt <= tick_cnt + 1'b1;
    end

    assert_pulse_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
        32'(tick_cnt) <= PULSE_TICKS);

    assert_flag_needs_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(stra_edge));

    assert_ready_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_q && strb_act && stra_edge && !ctrl_w) |=> !strb_act);

    assert_flag_clear_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q) |-> $past(bus_sel && (bus_rd || bus_wr) && bus_addr == A_LATCH));

    assert_dir_lines_driven_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_q & ~port_oe) == '0);

    assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag_q);

    assert_latch_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_out_hs && !stra_edge) |=> $stable(latch_q));
endmodule

bind strobe_port_ctrl spp_port_chk #(.DATA_W(DATA_W), .PULSE_TICKS(PULSE_TICKS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .e_tick    (e_tick),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .port_oe   (port_oe),
    .dir_q     (dir_q),
    .latch_q   (latch_q),
    .irq       (irq),
    .flag_q    (flag_q),
    .stra_edge (stra_edge),
    .strb_act  (strb_act),
    .hs_q      (hs_q),
    .in_out_hs (in_out_hs)
);

// File: tb/strobe_port_ctrl_tb.sv
module strobe_port_ctrl_tb_top;
    localparam int P = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       e_tick = 1'b1;
    logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata, port_out, port_oe, comp_out;
    logic [7:0] port_in = '0;
    logic       stra_in = 1'b0;
    logic       strb_out, irq;
    logic       tick_div = 1'b0;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    strobe_port_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .e_tick(e_tick),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .port_in(port_in), .port_out(port_out), .port_oe(port_oe),
        .comp_out(comp_out), .stra_in(stra_in), .strb_out(strb_out), .irq(irq)
    );

    // ---------------- reference model ----------------
    bit m_pol, m_edge, m_pulse, m_odir, m_hs, m_ie, m_flag, m_arm, m_on;
    int m_left;
    bit h0, h1, h2;
    logic [7:0] m_dir, m_data, m_latch, m_comp;

    always @(negedge clk) e_tick <= tick_div ? ~e_tick : 1'b1;

    always @(posedge clk) begin
        bit e, sm, im, om, wr, rd, on_n, nim;
        int left_n;
        if (!rst_n) begin
            m_pol = 1; m_edge = 1; m_pulse = 0; m_odir = 0; m_hs = 0; m_ie = 0;
            m_flag = 0; m_arm = 0; m_on = 0; m_left = 0;
            h0 = 0; h1 = 0; h2 = 0;
            m_dir = 0; m_data = 0; m_latch = 0; m_comp = 0;
        end else begin
            e  = m_edge ? (h1 && !h2) : (!h1 && h2);
            sm = !m_hs; im = m_hs && !m_odir; om = m_hs && m_odir;
            wr = bus_sel && bus_wr; rd = bus_sel && bus_rd;
            on_n = m_on; left_n = m_left;
            if (wr && bus_addr == 0) begin
                nim = bus_wdata[4] && !bus_wdata[3];
                on_n = nim; left_n = (nim && bus_wdata[2]) ? P : 0;
            end else if (!m_on) begin
                if ((sm && wr && bus_addr == 4) || (om && wr && bus_addr == 2) ||
                    (im && rd && bus_addr == 2)) begin
                    on_n = 1; left_n = (sm || m_pulse) ? P : 0;
                end
            end else if (m_left > 0) begin
                if (!sm && e) begin on_n = 0; left_n = 0; end
                else if (sm && wr && bus_addr == 4) left_n = P;
                else if (e_tick) begin
                    if (m_left == 1) begin on_n = 0; left_n = 0; end
                    else left_n = m_left - 1;
                end
            end else if (!sm && e) on_n = 0;
            // flag and latch
            if (e) m_flag = 1;
            else if (m_arm && (om ? (wr && bus_addr == 2) : (rd && bus_addr == 2))) begin
                m_flag = 0; m_arm = 0;
            end
            if (rd && bus_addr == 0 && m_flag && !e) m_arm = 1;
            else if (rd && bus_addr == 0 && m_flag) m_arm = 1;
            if (e && !om) m_latch = port_in;
            else if (om && wr && bus_addr == 2) m_latch = bus_wdata;
            if (wr && bus_addr == 0) begin
                m_pol = bus_wdata[0]; m_edge = bus_wdata[1]; m_pulse = bus_wdata[2];
                m_odir = bus_wdata[3]; m_hs = bus_wdata[4]; m_ie = bus_wdata[5];
            end
            if (wr && bus_addr == 1) m_data = bus_wdata;
            if (wr && bus_addr == 3) m_dir = bus_wdata;
            if (wr && bus_addr == 4) m_comp = bus_wdata;
            m_on = on_n; m_left = left_n;
            h2 = h1; h1 = h0; h0 = stra_in;
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_rdata();
        case (bus_addr)
            3'd0: return {m_flag, 1'b0, m_ie, m_hs, m_odir, m_pulse, m_edge, m_pol};
            3'd1: return (m_data & m_dir) | (port_in & ~m_dir);
            3'd2: return m_latch;
            3'd3: return m_dir;
            3'd4: return m_comp;
            default: return 8'h00;
        endcase
    endfunction

    // per-cycle comparison against the model
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            chk("R2 strb_out model", {7'd0, strb_out}, {7'd0, m_pol ? m_on : !m_on});
            chk("R2 comp_out model", comp_out, m_comp);
            chk("R10 irq model", {7'd0, irq}, {7'd0, m_flag && m_ie});
            chk("R8 port_oe model", port_oe,
                (m_hs && m_odir && (h1 == m_edge)) ? 8'hFF : m_dir);
            chk("R9 port_out model", port_out, (m_hs && m_odir) ? m_latch : m_data);
            chk("R7 rdata model", bus_rdata, exp_rdata());
        end
    end

    // ---------------- stimulus ----------------
    task automatic bwrite(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic bread(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_rd = 1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0; bus_rd = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_strb(input logic lvl, output int n);
        n = 0;
        for (int i = 0; i < 8; i++) begin
            if (strb_out == lvl) n++;
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        logic [7:0] v;
        int n;
        idle(4);
        rst_n = 1;
        idle(2);
        // R1 reset state
        bread(3'd0, v); chk("R1 ctrl reset", v, 8'h03);
        bread(3'd3, v); chk("R1 dir reset", v, 8'h00);
        bread(3'd2, v); chk("R1 latch reset", v, 8'h00);
        chk("R1 strb idle", {7'd0, strb_out}, 8'h00);
        chk("R1 irq idle", {7'd0, irq}, 8'h00);
        chk("R1 oe idle", port_oe, 8'h00);
        // R8 direction and data
        bwrite(3'd3, 8'hF0); bwrite(3'd1, 8'h5A); port_in = 8'h0F;
        idle(1);
        chk("R8 oe", port_oe, 8'hF0);
        chk("R8 out", port_out, 8'h5A);
        bread(3'd1, v); chk("R8 data read mix", v, 8'h5F);
        // R2 simple strobe pulse, both polarities
        bwrite(3'd4, 8'h77);
        count_strb(1'b1, n); chk("R2 pulse high width", 8'(n), 8'd2);
        chk("R2 comp value", comp_out, 8'h77);
        bwrite(3'd0, 8'h02);
        chk("R2 idle high when active low", {7'd0, strb_out}, 8'h01);
        bwrite(3'd4, 8'h12);
        count_strb(1'b0, n); chk("R2 pulse low width", 8'(n), 8'd2);
        bwrite(3'd0, 8'h03);
        // R3 rising edge capture
        port_in = 8'hA5; stra_in = 1; idle(4);
        bread(3'd2, v); chk("R3 latch on rise", v, 8'hA5);
        bread(3'd0, v); chk("R7 unarmed read keeps flag", v & 8'h80, 8'h80);
        bread(3'd2, v);
        bread(3'd0, v); chk("R7 flag cleared", v & 8'h80, 8'h00);
        // R3 opposite edge ignored
        port_in = 8'h3C; stra_in = 0; idle(4);
        bread(3'd0, v); chk("R3 no flag on fall", v & 8'h80, 8'h00);
        bread(3'd2, v); chk("R3 latch held on fall", v, 8'hA5);
        // R10 interrupt
        bwrite(3'd0, 8'h23);
        stra_in = 1; idle(4);
        chk("R10 irq set", {7'd0, irq}, 8'h01);
        bwrite(3'd0, 8'h03);
        chk("R10 irq masked", {7'd0, irq}, 8'h00);
        bread(3'd0, v); bread(3'd2, v);
        // R3 falling edge select
        bwrite(3'd0, 8'h01);
        port_in = 8'hC3; stra_in = 0; idle(4);
        bread(3'd2, v); chk("R3 latch on fall select", v, 8'hC3);
        bwrite(3'd0, 8'h03);
        bread(3'd0, v); bread(3'd2, v);
        // R11 latch write ignored outside output handshake
        bwrite(3'd2, 8'h11);
        bread(3'd2, v); chk("R11 latch write ignored", v, 8'hC3);
        // R4 input handshake level
        bwrite(3'd0, 8'h13);
        chk("R4 ready on entry", {7'd0, strb_out}, 8'h01);
        port_in = 8'h5E; stra_in = 1; idle(4);
        chk("R4 ready dropped", {7'd0, strb_out}, 8'h00);
        bread(3'd2, v); chk("R4 latch value", v, 8'h5E);
        chk("R4 ready again", {7'd0, strb_out}, 8'h01);
        stra_in = 0; idle(4);
        // R6 input handshake pulse
        bwrite(3'd0, 8'h17);
        count_strb(1'b1, n); chk("R6 pulse on entry", 8'(n), 8'd2);
        stra_in = 1; idle(4); stra_in = 0; idle(4);
        bread(3'd2, v);
        count_strb(1'b1, n); chk("R6 pulse after read", 8'(n), 8'd2);
        bread(3'd0, v); bread(3'd2, v);
        // R5 / R9 output handshake with three-state lines
        bwrite(3'd0, 8'h1B);
        bwrite(3'd3, 8'h0F);
        chk("R5 idle on entry", {7'd0, strb_out}, 8'h00);
        bwrite(3'd2, 8'h96);
        chk("R5 data ready", {7'd0, strb_out}, 8'h01);
        chk("R9 oe follows dir", port_oe, 8'h0F);
        chk("R9 out from latch", port_out, 8'h96);
        stra_in = 1; idle(4);
        chk("R9 all lines driven", port_oe, 8'hFF);
        chk("R5 ack drops strobe", {7'd0, strb_out}, 8'h00);
        bread(3'd0, v); chk("R5 ack sets flag", v & 8'h80, 8'h80);
        bwrite(3'd2, 8'h69);
        bread(3'd0, v); chk("R7 cleared by latch write", v & 8'h80, 8'h00);
        chk("R5 strobe on new data", {7'd0, strb_out}, 8'h01);
        stra_in = 0; idle(4);
        chk("R9 lines released", port_oe, 8'h0F);
        // divided tick, compared by the model each cycle
        bwrite(3'd0, 8'h03);
        tick_div = 1;
        bwrite(3'd4, 8'h21); idle(6);
        bwrite(3'd4, 8'h22); idle(1); bwrite(3'd4, 8'h23); idle(8);
        tick_div = 0;
        idle(4);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end
endmodule